// File: doc/BRIEF.md
# Write-Protected Clock and Reset Controller

This block switches the clocks of up to twelve banks of 32 peripheral modules on and off, and asserts and releases each module's software reset. Software reaches it over a plain register bus with address, write data, write and read strobes, and a combinational read data path. It also controls one derived core clock: a divider field and a stop flag set the rate of a one-cycle enable pulse, which downstream logic uses to gate its work.

Clock gating writes take effect at once. Reset and core clock writes are guarded. A write to the key register loads a key and arms it. Only the bus write that comes next can use the key, and it is accepted only if its data is the exact bitwise inverse of that key. An accepted guarded write does not act at once. It waits a fixed number of system clock cycles, which stands in for the crossing into a slow reference domain. During that wait a busy flag can be read, and any further guarded write is dropped.

Top module: `ccr_top`

## Requirements
- R1: After reset every module clock enable is 0, every module reset line is 1, the core clock enable stays 0, the core control register reads 0x100 and the busy flag reads 0.
- R2: Stop bank i sits at 0x110+4i for i<8 and at 0x980+4(i-8) for i>=8. Its writes are not guarded and act at the next clock edge. A 1 in bit b turns off the clock enable of module 32i+b, and a 0 turns it on. A read returns the stored value.
- R3: A write to 0x900 loads the key. The next bus write to a guarded register is accepted only when its data equals the bitwise inverse of the key.
- R4: A guarded write with no armed key, or with data that is not the inverse of the key, changes nothing.
- R5: Any bus write consumes the armed key, whatever its address, including an unmapped one. A guarded write after that is dropped.
- R6: An accepted guarded write changes the outputs exactly SETTLE_CYCLES clock edges after the edge that accepts it. Until then bit 0 at 0x904 reads 1. A guarded write made while that flag is 1 is dropped.
- R7: Reset-set bank i sits at 0x0A0, 0x0A8, 0x0B0, 0x0B8, 0x0BC, 0x0C4, 0x1C8, 0x1CC for i=0..7 and at 0x920+4(i-8) after that. A 1 bit asserts the reset of that module. A 0 bit has no effect. A read returns the current reset lines of the bank.
- R8: Reset-clear bank i sits at 0x940+4i. A 1 bit releases the reset of that module. A 0 bit has no effect. A read returns 0.
- R9: The core control register at 0x244 is guarded. Bit 8 set holds the core enable at 0. With bit 8 clear, bits 7:0 hold N, and the enable pulses once in every N+1 cycles. A read returns the stored register.
- R10: A read from an unmapped address returns 0, and a write to one changes no state except that it consumes the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the core clock's parent |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; read data is 0 when it is low |
| bus_rdata | output | DATA_W | Combinational read data |
| mod_clk_en | output | NUM_BANKS*DATA_W | Clock enable for each module, bank i in slice i |
| mod_rst | output | NUM_BANKS*DATA_W | Reset line for each module, active high |
| core_clk_en | output | 1 | Enable pulse for the divided core clock |

## Verification
The guarded path is tried with a correct key, a wrong key, no key, a key used up by a stop write, a key used up by an unmapped write, and a second write made while busy. Only the first of these may change the reset lines, so the bench can tell a correct comparison from one that skips the key or never clears the arm. Set and clear writes are made with sparse masks on lines that are already partly released, which exposes any design that writes whole words instead of single bits. The core enable is counted over 24 cycles at N=2, N=0 and with the stop flag set, giving 8, 24 and 0 pulses. Outputs are sampled one edge before and at the end of the settling wait, which catches a delay that is one edge short or one edge long.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_STOP = 3'd1,
      TGT_SET  = 3'd2,
      TGT_CLR  = 3'd3,
      TGT_CORE = 3'd4,
      TGT_KEY  = 3'd5,
      TGT_STAT = 3'd6
   } tgt_e;

   localparam int unsigned MAX_BANKS  = 12;
   localparam logic [15:0] KEY_OFF    = 16'h0900;
   localparam logic [15:0] STAT_OFF   = 16'h0904;
   localparam logic [15:0] CORE_OFF   = 16'h0244;
   localparam int unsigned CORE_STOP_BIT = 8;

   function automatic logic [15:0] stop_off(input int i);
      if (i < 8) return 16'h0110 + 16'(4 * i);
      else       return 16'h0980 + 16'(4 * (i - 8));
   endfunction

   function automatic logic [15:0] set_off(input int i);
      case (i)
         0, 1, 2, 3: return 16'h00A0 + 16'(8 * i);
         4:          return 16'h00BC;
         5:          return 16'h00C4;
         6:          return 16'h01C8;
         7:          return 16'h01CC;
         default:    return 16'h0920 + 16'(4 * (i - 8));
      endcase
   endfunction

   function automatic logic [15:0] clr_off(input int i);
      return 16'h0940 + 16'(4 * i);
   endfunction

endpackage

// File: rtl/ccr_addr_decode.sv
module ccr_addr_decode
   import ccr_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 12,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output tgt_e              kind,
   output logic [IDX_W-1:0]  idx
);

   logic [NUM_BANKS-1:0] hit_stop, hit_set, hit_clr;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      assign hit_stop[g] = (addr == ADDR_W'(stop_off(g)));
      assign hit_set[g]  = (addr == ADDR_W'(set_off(g)));
      assign hit_clr[g]  = (addr == ADDR_W'(clr_off(g)));
   end

   always_comb begin
      kind = TGT_NONE;
      idx  = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (hit_stop[i]) begin kind = TGT_STOP; idx = IDX_W'(i); end
         if (hit_set[i])  begin kind = TGT_SET;  idx = IDX_W'(i); end
         if (hit_clr[i])  begin kind = TGT_CLR;  idx = IDX_W'(i); end
      end
      if (addr == ADDR_W'(KEY_OFF))  kind = TGT_KEY;
      if (addr == ADDR_W'(STAT_OFF)) kind = TGT_STAT;
      if (addr == ADDR_W'(CORE_OFF)) kind = TGT_CORE;
   end

endmodule

// File: rtl/ccr_protect_gate.sv
module ccr_protect_gate
   import ccr_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned IDX_W         = 4,
   parameter int unsigned SETTLE_CYCLES = 6,
   localparam int unsigned CNT_W        = $clog2(SETTLE_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  tgt_e              kind,
   input  logic [IDX_W-1:0]  idx,
   output logic              busy,
   output logic              commit,
   output tgt_e              commit_kind,
   output logic [IDX_W-1:0]  commit_idx,
   output logic [DATA_W-1:0] commit_data
);

   logic [DATA_W-1:0] key_q;
   logic              armed_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic              guarded, accept;

   assign guarded = (kind == TGT_SET) || (kind == TGT_CLR) || (kind == TGT_CORE);
   assign accept  = wr_en && guarded && armed_q && !busy_q && (wdata == ~key_q);
   assign busy    = busy_q;
   assign commit  = busy_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q   <= '0;
         armed_q <= 1'b0;
      end else if (wr_en) begin
         if (kind == TGT_KEY) begin
            key_q   <= wdata;
            armed_q <= 1'b1;
         end else begin
            armed_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         cnt_q       <= '0;
         commit_kind <= TGT_NONE;
         commit_idx  <= '0;
         commit_data <= '0;
      end else if (accept) begin
         busy_q      <= 1'b1;
         cnt_q       <= CNT_W'(SETTLE_CYCLES - 1);
         commit_kind <= kind;
         commit_idx  <= idx;
         commit_data <= wdata;
      end else if (commit) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/ccr_core_div.sv
module ccr_core_div #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic [DIV_W-1:0] div,
   output logic             en
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q >= div);
   assign en   = !stop && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (stop)  cnt_q <= '0;
      else if (wrap)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/ccr_top.sv
module ccr_top
   import ccr_pkg::*;
#(
   parameter int unsigned NUM_BANKS     = 12,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 12,
   parameter int unsigned DIV_W         = 8,
   parameter int unsigned SETTLE_CYCLES = 6,
   localparam int unsigned IDX_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned MOD_W        = NUM_BANKS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [MOD_W-1:0]  mod_clk_en,
   output logic [MOD_W-1:0]  mod_rst,
   output logic              core_clk_en
);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("ccr_top: NUM_BANKS must be 1..12");
   end
   if (DIV_W < 1 || DIV_W > CORE_STOP_BIT) begin : g_bad_div
      $error("ccr_top: DIV_W must be 1..8");
   end
   if (DATA_W <= CORE_STOP_BIT) begin : g_bad_data
      $error("ccr_top: DATA_W must exceed the stop bit position");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ccr_top: ADDR_W must reach offset 0x98C");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("ccr_top: SETTLE_CYCLES must be at least 1");
   end

   tgt_e              kind;
   logic [IDX_W-1:0]  idx;
   logic              busy;
   logic              commit;
   tgt_e              commit_kind;
   logic [IDX_W-1:0]  commit_idx;
   logic [DATA_W-1:0] commit_data;

   logic [DATA_W-1:0] stop_q [NUM_BANKS];
   logic [DATA_W-1:0] rst_q  [NUM_BANKS];
   logic              core_stop_q;
   logic [DIV_W-1:0]  core_div_q;

   ccr_addr_decode #(
      .NUM_BANKS(NUM_BANKS),
      .ADDR_W   (ADDR_W)
   ) u_dec (
      .addr(bus_addr),
      .kind(kind),
      .idx (idx)
   );

   ccr_protect_gate #(
      .DATA_W       (DATA_W),
      .IDX_W        (IDX_W),
      .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr),
      .wdata      (bus_wdata),
      .kind       (kind),
      .idx        (idx),
      .busy       (busy),
      .commit     (commit),
      .commit_kind(commit_kind),
      .commit_idx (commit_idx),
      .commit_data(commit_data)
   );

   ccr_core_div #(
      .DIV_W(DIV_W)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .stop (core_stop_q),
      .div  (core_div_q),
      .en   (core_clk_en)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stop_q[b] <= '1;
         end else if (bus_wr && kind == TGT_STOP && idx == IDX_W'(b)) begin
            stop_q[b] <= bus_wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rst_q[b] <= '1;
         end else if (commit && commit_idx == IDX_W'(b)) begin
            if (commit_kind == TGT_SET)      rst_q[b] <= rst_q[b] | commit_data;
            else if (commit_kind == TGT_CLR) rst_q[b] <= rst_q[b] & ~commit_data;
         end
      end

      assign mod_clk_en[b*DATA_W +: DATA_W] = ~stop_q[b];
      assign mod_rst[b*DATA_W +: DATA_W]    = rst_q[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_stop_q <= 1'b1;
         core_div_q  <= '0;
      end else if (commit && commit_kind == TGT_CORE) begin
         core_stop_q <= commit_data[CORE_STOP_BIT];
         core_div_q  <= commit_data[DIV_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (kind)
            TGT_STOP: bus_rdata = stop_q[idx];
            TGT_SET:  bus_rdata = rst_q[idx];
            TGT_CORE: begin
               bus_rdata[CORE_STOP_BIT] = core_stop_q;
               bus_rdata[DIV_W-1:0]     = core_div_q;
            end
            TGT_STAT: bus_rdata[0] = busy;
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
   parameter int unsigned MOD_W         = 384,
   parameter int unsigned SETTLE_CYCLES = 6,
   localparam int unsigned RUN_W        = $clog2(SETTLE_CYCLES + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [MOD_W-1:0] mod_clk_en,
   input logic [MOD_W-1:0] mod_rst,
   input logic             core_clk_en,
   input logic             busy,
   input logic             core_stop
);

   logic [RUN_W-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   // R6: the wait never outlasts the configured count
   a_r6_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < RUN_W'(SETTLE_CYCLES)));

   // R6: a wait only starts from a bus write
   a_r6_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_wr));

   // R2: clock enables move only after a bus write
   a_r2_clk_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_clk_en) |-> $past(bus_wr));

   // R7: reset lines move only when a wait finishes
   a_r7_rst_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_rst) |-> $fell(busy));

   // R9: a stopped core clock never pulses
   a_r9_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
      core_stop |-> !core_clk_en);

endmodule

bind ccr_top ccr_checker #(
   .MOD_W        (MOD_W),
   .SETTLE_CYCLES(SETTLE_CYCLES)
) u_ccr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .mod_clk_en (mod_clk_en),
   .mod_rst    (mod_rst),
   .core_clk_en(core_clk_en),
   .busy       (busy),
   .core_stop  (core_stop_q)
);

// File: tb/tb_ccr_top.sv
module tb_ccr_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 12;
   localparam int DW         = 32;
   localparam int AW         = 12;
   localparam int SETTLE     = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [DW-1:0]     bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [DW-1:0]     bus_rdata;
   logic [NB*DW-1:0]  mod_clk_en;
   logic [NB*DW-1:0]  mod_rst;
   logic              core_clk_en;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ccr_top #(
      .NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW), .DIV_W(8), .SETTLE_CYCLES(SETTLE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .mod_clk_en(mod_clk_en), .mod_rst(mod_rst), .core_clk_en(core_clk_en)
   );

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] clk_bank(input int i);
      return mod_clk_en[i*DW +: DW];
   endfunction

   function automatic logic [DW-1:0] rst_bank(input int i);
      return mod_rst[i*DW +: DW];
   endfunction

   // called at a falling edge, returns at the next falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      d        = bus_rdata;
      bus_rd   = 1'b0;
   endtask

   task automatic pwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr(12'h900, ~d);
      wr(a, d);
   endtask

   task automatic count_pulses(output int n);
      n = 0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (core_clk_en) n++;
      end
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      chk("R1", "clk_en bank0", clk_bank(0), 32'h0);
      chk("R1", "clk_en bank11", clk_bank(11), 32'h0);
      chk("R1", "rst bank5", rst_bank(5), 32'hFFFF_FFFF);
      chk("R1", "core_clk_en", {31'b0, core_clk_en}, 32'h0);
      rd(12'h244, v); chk("R1", "core ctrl", v, 32'h100);
      rd(12'h904, v); chk("R1", "busy", v, 32'h0);
   endtask

   task automatic t_stop;
      logic [DW-1:0] v;
      wr(12'h110, 32'h0000_00F0);
      chk("R2", "clk_en bank0", clk_bank(0), 32'hFFFF_FF0F);
      rd(12'h110, v); chk("R2", "stop bank0 readback", v, 32'h0000_00F0);
      wr(12'h12C, 32'h0000_0001);
      chk("R2", "clk_en bank7", clk_bank(7), 32'hFFFF_FFFE);
      wr(12'h98C, 32'h0);
      chk("R2", "clk_en bank11", clk_bank(11), 32'hFFFF_FFFF);
      chk("R2", "clk_en bank8 untouched", clk_bank(8), 32'h0);
   endtask

   task automatic t_clear_timing;
      logic [DW-1:0] v;
      pwr(12'h940, 32'h0000_000F);
      repeat (SETTLE - 1) @(negedge clk);
      chk("R6", "rst bank0 before settle", rst_bank(0), 32'hFFFF_FFFF);
      rd(12'h904, v); chk("R6", "busy during settle", v, 32'h1);
      @(negedge clk);
      chk("R8", "rst bank0 after clear", rst_bank(0), 32'hFFFF_FFF0);
      rd(12'h904, v); chk("R6", "busy after settle", v, 32'h0);
      rd(12'h0A0, v); chk("R7", "reset state readback", v, 32'hFFFF_FFF0);
      rd(12'h940, v); chk("R8", "clear reg reads 0", v, 32'h0);
   endtask

   task automatic t_set;
      logic [DW-1:0] v;
      pwr(12'h0A0, 32'h0000_0001);
      repeat (SETTLE) @(negedge clk);
      chk("R7", "set bit0 zeros ignored", rst_bank(0), 32'hFFFF_FFF1);
      pwr(12'h950, 32'hFFFF_FFFF);
      repeat (SETTLE) @(negedge clk);
      chk("R8", "rst bank4 cleared", rst_bank(4), 32'h0);
      rd(12'h0BC, v); chk("R7", "bank4 readback", v, 32'h0);
      pwr(12'h0BC, 32'h0000_0100);
      repeat (SETTLE) @(negedge clk);
      chk("R7", "bank4 set bit8", rst_bank(4), 32'h0000_0100);
      pwr(12'h92C, 32'h0);
      repeat (SETTLE) @(negedge clk);
      chk("R3", "key write bank11 accepted", rst_bank(11), 32'hFFFF_FFFF);
   endtask

   task automatic t_busy_drop;
      pwr(12'h944, 32'h0000_0001);
      pwr(12'h944, 32'h0000_0002);
      repeat (SETTLE + 2) @(negedge clk);
      chk("R6", "write while busy dropped", rst_bank(1), 32'hFFFF_FFFE);
   endtask

   task automatic t_bad_key;
      logic [DW-1:0] v;
      wr(12'h900, 32'h1234_5678);
      wr(12'h944, 32'h0000_FFFF);
      repeat (SETTLE + 2) @(negedge clk);
      chk("R4", "wrong inverse dropped", rst_bank(1), 32'hFFFF_FFFE);
      wr(12'h948, 32'h0000_0001);
      repeat (SETTLE + 2) @(negedge clk);
      chk("R4", "no key dropped", rst_bank(2), 32'hFFFF_FFFF);
      rd(12'h904, v); chk("R4", "no wait started", v, 32'h0);
   endtask

   task automatic t_consumed;
      logic [DW-1:0] v;
      wr(12'h900, ~32'h0000_0004);
      wr(12'h114, 32'h0);
      wr(12'h948, 32'h0000_0004);
      repeat (SETTLE + 2) @(negedge clk);
      chk("R5", "key used by stop write", rst_bank(2), 32'hFFFF_FFFF);
      chk("R2", "stop write applied", clk_bank(1), 32'hFFFF_FFFF);
      wr(12'h900, ~32'h0000_0008);
      wr(12'h7FC, 32'hDEAD_BEEF);
      wr(12'h948, 32'h0000_0008);
      repeat (SETTLE + 2) @(negedge clk);
      chk("R10", "key used by unmapped write", rst_bank(2), 32'hFFFF_FFFF);
      rd(12'h7FC, v); chk("R10", "unmapped read", v, 32'h0);
   endtask

   task automatic t_core;
      logic [DW-1:0] v;
      int n;
      pwr(12'h244, 32'h0000_0002);
      repeat (SETTLE) @(negedge clk);
      count_pulses(n); chk("R9", "pulses N=2", 32'(n), 32'd8);
      rd(12'h244, v); chk("R9", "core readback", v, 32'h0000_0002);
      pwr(12'h244, 32'h0);
      repeat (SETTLE) @(negedge clk);
      count_pulses(n); chk("R9", "pulses N=0", 32'(n), 32'd24);
      pwr(12'h244, 32'h0000_0105);
      repeat (SETTLE) @(negedge clk);
      count_pulses(n); chk("R9", "pulses stopped", 32'(n), 32'd0);
      rd(12'h244, v); chk("R9", "stopped readback", v, 32'h0000_0105);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_stop;
      t_clear_timing;
      t_set;
      t_busy_drop;
      t_bad_key;
      t_consumed;
      t_core;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule